// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block converts a 32-bit virtual address into a 30-bit physical address in two steps. The top three address bits select one of eight segment registers. Each segment register holds the physical base of that segment's page table and a limit on the page numbers it covers. If the page number is within the limit, the block reads one page-table entry from memory. The physical page number in that entry is joined with the 12-bit page offset to form the result. If the page number is above the limit, the block returns an error and does not touch memory.

Software loads the segment registers through a plain write port. A requester sends a virtual address on a valid/ready request channel and gets back the physical address and an error flag on a valid/ready response channel. The block handles one translation at a time. The request channel is ready only while nothing is in flight. The memory read port and the response channel both hold their contents unchanged while the other side withholds ready, so a slow memory or a stalled requester only adds cycles. A read completes in the cycle in which `mem_valid` and `mem_ready` are both high, and `mem_rdata` is sampled in that same cycle.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_valid` is 0. Every segment register holds base 0 and limit 0.
- R2: When `cfg_we` is high at a clock edge, segment register `cfg_sel` takes `cfg_base` and `cfg_limit`. Every translation accepted after that edge uses the new values.
- R3: The request address is split into three fields: segment number in `req_vaddr[31:29]`, virtual page number in `req_vaddr[28:12]`, and offset in `req_vaddr[11:0]`.
- R4: A page number greater than the segment's limit gives a response with `rsp_err`=1 and `rsp_paddr`=0, and no memory read is issued for that request. A page number equal to the limit is valid.
- R5: The entry address on `mem_addr` is the segment base plus four times the page number, taken modulo 2^30.
- R6: A successful response has `rsp_err`=0 and `rsp_paddr` = {`mem_rdata`[17:0], offset}. The `mem_rdata` value is the one sampled when the read completed.
- R7: Only one translation is in flight at a time. `req_ready` is high only when no read and no response is pending, and it drops in the cycle after a request is accepted.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` does not change.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_err` stay unchanged.
- R10: Latency, counting clock edges after the accepting edge:
  - An error response appears after the second edge.
  - `mem_valid` appears after the second edge.
  - A successful response appears after the edge that completes the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 3 | Segment register to write |
| cfg_base | input | 30 | Page-table base to store |
| cfg_limit | input | 17 | Highest valid page number to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 30 | Translated physical address (0 on error) |
| rsp_err | output | 1 | Page number beyond the segment limit |
| mem_valid | output | 1 | Page-table read request valid |
| mem_ready | input | 1 | Memory completes the read this cycle |
| mem_addr | output | 30 | Byte address of the page-table entry |
| mem_rdata | input | 18 | Physical page number from the entry |

## Verification
The hardest situations to reach from the ports are translations at the boundaries. These include a page number exactly equal to a segment's limit, the largest page number against the largest limit, and an entry address that wraps past the top of the 30-bit space. Each of these requires a segment register that was loaded beforehand with a matching base and limit. The bench loads all eight segments with values chosen to land on these edges. It then walks a vector table in which each entry also sets how many cycles the memory and the requester withhold ready. This exercises the hold rules and the latency count in the same pass. Directed cases follow the table:
- a reset while a read is outstanding;
- a check that reset cleared the segment table;
- a rewrite of a segment register between two translations.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int DEF_SEG_W  = 3;
  localparam int DEF_VPN_W  = 17;
  localparam int DEF_OFF_W  = 12;
  localparam int DEF_PA_W   = 30;
  localparam int DEF_PTE_BY = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 3,
  parameter int VPN_W = 17,
  parameter int PA_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_sel,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [VPN_W-1:0] wr_limit,
  input  logic [SEG_W-1:0] rd_sel,
  output logic [PA_W-1:0]  rd_base,
  output logic [VPN_W-1:0] rd_limit
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [VPN_W-1:0] limit_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEG_W'(g))) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
      end
    end
  end

  assign rd_base  = base_q[rd_sel];
  assign rd_limit = limit_q[rd_sel];
endmodule

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int VPN_W     = 17,
  parameter int PA_W      = 30,
  parameter int PTE_SHIFT = 2
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] limit,
  input  logic [VPN_W-1:0] vpn,
  output logic             over_limit,
  output logic [PA_W-1:0]  entry_addr
);
  logic [PA_W-1:0] scaled;

  always_comb begin
    scaled     = PA_W'(vpn) << PTE_SHIFT;
    entry_addr = base + scaled;
    over_limit = (vpn > limit);
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int VPN_W = 17,
  parameter int OFF_W = 12,
  parameter int PA_W  = 30,
  parameter int PPN_W = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [SEG_W+VPN_W+OFF_W-1:0] req_vaddr,
  output logic [SEG_W-1:0]             seg_idx,
  output logic [VPN_W-1:0]             vpn_cur,
  input  logic                         over_limit,
  input  logic [PA_W-1:0]              entry_addr,
  output logic                         mem_valid,
  input  logic                         mem_ready,
  output logic [PA_W-1:0]              mem_addr,
  input  logic [PPN_W-1:0]             mem_rdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [PA_W-1:0]              rsp_paddr,
  output logic                         rsp_err
);
  xl_state_t        state_q;
  logic [SEG_W-1:0] seg_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  pte_q;
  logic [PA_W-1:0]  paddr_q;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      pte_q   <= '0;
      paddr_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            seg_q   <= req_vaddr[SEG_W+VPN_W+OFF_W-1 -: SEG_W];
            vpn_q   <= req_vaddr[VPN_W+OFF_W-1 -: VPN_W];
            off_q   <= req_vaddr[OFF_W-1:0];
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (over_limit) begin
            err_q   <= 1'b1;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            pte_q   <= entry_addr;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            err_q   <= 1'b0;
            paddr_q <= {mem_rdata, off_q};
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = (state_q == ST_READ);
  assign rsp_valid = (state_q == ST_RESP);
  assign mem_addr  = pte_q;
  assign rsp_paddr = paddr_q;
  assign rsp_err   = err_q;
  assign seg_idx   = seg_q;
  assign vpn_cur   = vpn_q;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W     = DEF_SEG_W,
  parameter int VPN_W     = DEF_VPN_W,
  parameter int OFF_W     = DEF_OFF_W,
  parameter int PA_W      = DEF_PA_W,
  parameter int PTE_BYTES = DEF_PTE_BY,
  localparam int VA_W     = SEG_W + VPN_W + OFF_W,
  localparam int PPN_W    = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_sel,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [VPN_W-1:0] cfg_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_err,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [PA_W-1:0]  mem_addr,
  input  logic [PPN_W-1:0] mem_rdata
);
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  logic [SEG_W-1:0] seg_idx;
  logic [VPN_W-1:0] vpn_cur;
  logic [PA_W-1:0]  seg_base;
  logic [VPN_W-1:0] seg_limit;
  logic             over_limit;
  logic [PA_W-1:0]  entry_addr;

  seg_regfile #(.SEG_W(SEG_W), .VPN_W(VPN_W), .PA_W(PA_W)) u_segs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .rd_sel   (seg_idx),
    .rd_base  (seg_base),
    .rd_limit (seg_limit)
  );

  pte_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W), .PTE_SHIFT(PTE_SHIFT)) u_addr (
    .base       (seg_base),
    .limit      (seg_limit),
    .vpn        (vpn_cur),
    .over_limit (over_limit),
    .entry_addr (entry_addr)
  );

  xlate_ctrl #(
    .SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PA_W(PA_W), .PPN_W(PPN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .seg_idx    (seg_idx),
    .vpn_cur    (vpn_cur),
    .over_limit (over_limit),
    .entry_addr (entry_addr),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_err    (rsp_err)
  );
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_err,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_addr
);
  p_idle_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_valid));

  p_accept_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_err)));

  p_err_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_err) |-> !$past(mem_valid));

  p_err_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0));

  p_ok_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_err) |-> $past(mem_valid && mem_ready));
endmodule

bind seg_page_xlate seg_page_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_paddr (rsp_paddr),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr)
);

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [29:0] cfg_base = '0;
  logic [16:0] cfg_limit = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [29:0] rsp_paddr;
  logic        rsp_err;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_addr;
  logic [17:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  seg_page_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  // vector: {segment, page number, offset, memory wait cycles}
  localparam logic [35:0] VEC [9] = '{
    {3'd0, 17'h00000, 12'h123, 4'd0},
    {3'd0, 17'h00001, 12'h000, 4'd0},
    {3'd1, 17'h00005, 12'hFFF, 4'd2},
    {3'd1, 17'h00006, 12'h001, 4'd0},
    {3'd2, 17'h1FFFF, 12'h800, 4'd1},
    {3'd3, 17'h00100, 12'h0AB, 4'd3},
    {3'd7, 17'h00008, 12'h456, 4'd0},
    {3'd5, 17'h1FFFF, 12'h000, 4'd0},
    {3'd6, 17'h00002, 12'h7FF, 4'd5}
  };

  function automatic logic [29:0] seg_base_of(input int s);
    case (s)
      0: return 30'h0000_1000;
      1: return 30'h0002_0000;
      2: return 30'h1000_0000;
      3: return 30'h0ABC_0000;
      4: return 30'h0000_4000;
      5: return 30'h2000_0000;
      6: return 30'h0000_0100;
      default: return 30'h3FFF_FFF0;
    endcase
  endfunction

  function automatic logic [16:0] seg_limit_of(input int s);
    case (s)
      0: return 17'h00000;
      1: return 17'h00005;
      2: return 17'h1FFFF;
      3: return 17'h00200;
      4: return 17'h00040;
      5: return 17'h01000;
      6: return 17'h00003;
      default: return 17'h00010;
    endcase
  endfunction

  function automatic logic [17:0] mem_model(input logic [29:0] a);
    return a[19:2] ^ 18'h15A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] s, input logic [29:0] b, input logic [16:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xlate(input logic [2:0] s, input logic [16:0] v, input logic [11:0] o,
                           input int mw, input int rw, input logic exp_err,
                           input logic [29:0] exp_pte);
    logic [29:0] exp_pa;
    logic [29:0] addr_seen = '0;
    logic [29:0] pa_seen = '0;
    logic        err_seen = 1'b0;
    int reads = 0, first_mem = 0, mem_waited = 0, rsp_n = 0, held = 0;
    bit ready_bad = 0, mem_hold_bad = 0, rsp_hold_bad = 0, got_rsp = 0, done = 0;
    exp_pa = exp_err ? 30'h0 : {mem_model(exp_pte), o};
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {s, v, o};
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= 80 && !done; n++) begin
      @(negedge clk);
      if (req_ready && !got_rsp) ready_bad = 1;
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (first_mem == 0) begin first_mem = n; addr_seen = mem_addr; end
        else if (mem_addr != addr_seen) mem_hold_bad = 1;
        if (mem_waited == mw) begin
          mem_ready = 1'b1; mem_rdata = mem_model(mem_addr); reads++;
        end else mem_waited++;
      end
      if (rsp_ready) begin
        rsp_ready = 1'b0; done = 1;
      end else if (rsp_valid) begin
        if (rsp_n == 0) begin rsp_n = n; pa_seen = rsp_paddr; err_seen = rsp_err; end
        else if (pa_seen != rsp_paddr || err_seen != rsp_err) rsp_hold_bad = 1;
        if (held == rw) begin rsp_ready = 1'b1; got_rsp = 1; end
        else held++;
      end
    end
    chk(done, "R7 translation completes", 64'(done), 64'd1);
    chk(err_seen == exp_err, "R4 error flag", 64'(err_seen), 64'(exp_err));
    chk(pa_seen == exp_pa, "R6 physical address (R3 fields)", 64'(pa_seen), 64'(exp_pa));
    if (exp_err) begin
      chk(reads == 0 && first_mem == 0, "R4 no memory read on error", 64'(reads), 64'd0);
      chk(rsp_n == 1, "R10 error latency", 64'(rsp_n), 64'd1);
    end else begin
      chk(addr_seen == exp_pte, "R5 entry address (R3 fields)", 64'(addr_seen), 64'(exp_pte));
      chk(first_mem == 1, "R10 read latency", 64'(first_mem), 64'd1);
      chk(rsp_n == mw + 2, "R10 response latency", 64'(rsp_n), 64'(mw + 2));
    end
    chk(!ready_bad, "R7 request not ready while busy", 64'(ready_bad), 64'd0);
    chk(!mem_hold_bad, "R8 read held under back-pressure", 64'(mem_hold_bad), 64'd0);
    chk(!rsp_hold_bad, "R9 response held under back-pressure", 64'(rsp_hold_bad), 64'd0);
  endtask

  function automatic logic [29:0] pte_of(input int s, input logic [16:0] v);
    return 30'(seg_base_of(s) + (30'(v) << 2));
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog R7 actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0 && mem_valid == 1'b0, "R1 reset outputs idle",
        64'({rsp_valid, mem_valid}), 64'd0);

    // R1: cleared table, limit 0 and base 0
    run_xlate(3'd4, 17'd1, 12'h010, 0, 0, 1'b1, 30'h0);
    run_xlate(3'd4, 17'd0, 12'h020, 0, 1, 1'b0, 30'h0);

    // R2: load all segments
    for (int s = 0; s < 8; s++) cfg_write(3'(s), seg_base_of(s), seg_limit_of(s));

    for (int i = 0; i < 9; i++) begin
      logic [2:0]  vs;
      logic [16:0] vv;
      logic [11:0] vo;
      logic [3:0]  vw;
      {vs, vv, vo, vw} = VEC[i];
      run_xlate(vs, vv, vo, int'(vw), i % 3, vv > seg_limit_of(int'(vs)), pte_of(int'(vs), vv));
    end

    // R2: rewrite segment 1 so page 6 becomes valid at a new base
    cfg_write(3'd1, 30'h0000_3000, 17'd6);
    run_xlate(3'd1, 17'd6, 12'h0C0, 1, 2, 1'b0, 30'h0000_3018);
    run_xlate(3'd1, 17'd7, 12'h0C0, 0, 0, 1'b1, 30'h0);

    // R1: reset while a read is outstanding
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {3'd3, 17'd4, 12'h000};
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(mem_valid == 1'b1, "R10 read pending before reset", 64'(mem_valid), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && rsp_valid == 1'b0,
        "R1 reset aborts translation", 64'({req_ready, mem_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    run_xlate(3'd3, 17'd4, 12'h000, 0, 0, 1'b1, 30'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule